// File: doc/BRIEF.md
# Smart card character receiver

This block takes in characters from a half-duplex, open-drain serial line that follows the asynchronous character protocol used between a card reader and a smart card. A character has one low start bit, eight data bits sent least significant bit first, and one even parity bit. Bit timing comes from a programmable elementary time unit (ETU), counted in clock cycles. Each bit is judged from a majority vote of three samples taken around the middle of the bit.

When a character arrives with correct parity, the block stores the byte, raises a data-ready flag and can request either an interrupt or a DMA transfer. When the parity is wrong, the block still stores the byte so software can inspect it. It sets a sticky parity-error flag, holds back the data-ready flag and pulls the line low for one time unit. That low pulse tells the sender to repeat the character. The repeated character is received as a fresh frame.

Software or a DMA engine clears the flags through single-cycle strobes. The line pin is modelled as an input `line_in` together with an output `line_drive_low`, which the pad uses to enable an open-drain pull-down.

Top module: `sc_char_rx`

## Requirements
- R1: Bits are taken LSB first after the start bit. Each bit is sampled half an ETU into the bit, where a bit lasts `etu_cycles` clocks (0 selects 372, and values below 4 are treated as 4). After a good character, `rd_data` holds the eight data bits.
- R2: A falling edge starts a frame only if the line is still low at the half-ETU point of the start bit. Otherwise the receiver goes back to idle with no flag change and no line drive.
- R3: A character whose ones count over the data bits and the parity bit is even sets `rdy_flag` the cycle after its parity sample and leaves `perr_flag` unchanged.
- R4: A character with odd parity sets `perr_flag` and loads its byte into `rd_data`, and `rdy_flag` does not rise for it.
- R5: After an odd-parity character, `line_drive_low` goes high half an ETU after the parity sample and stays high for exactly one ETU. It never goes high after a good character.
- R6: A good character that completes while `rdy_flag` is 1 sets `ovr_flag` and leaves `rd_data` unchanged.
- R7: `rxi_irq` equals `rdy_flag` AND `rie`, and `eri_irq` equals (`perr_flag` OR `ovr_flag`) AND `rie`.
- R8: `dma_req` equals `rdy_flag` AND `dma_en`. A `dma_ack` pulse clears `rdy_flag`, and a frame with a parity error causes no request.
- R9: The flags are 0 after reset. Each flag stays set until its clear strobe (`clr_rdy`, `clr_perr`, `clr_ovr`), and a set in the same cycle as a clear wins.
- R10: While `rx_en` is 0, traffic on the line changes no flag, no data and no line drive.
- R11: A single-clock glitch inside a bit does not change the decoded value of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| etu_cycles | input | 16 | Clocks per elementary time unit; 0 selects the default |
| rx_en | input | 1 | Receive enable |
| rie | input | 1 | Interrupt enable for both receive and error interrupts |
| dma_en | input | 1 | Use data-ready as a DMA trigger |
| line_in | input | 1 | Serial line as seen at the pad |
| dma_ack | input | 1 | DMA read done; clears data-ready |
| clr_rdy | input | 1 | Software clear of data-ready |
| clr_perr | input | 1 | Software clear of parity error |
| clr_ovr | input | 1 | Software clear of overrun |
| line_drive_low | output | 1 | Enable for the open-drain pull-down (error signal) |
| rd_data | output | 8 | Received byte |
| rdy_flag | output | 1 | Data ready |
| perr_flag | output | 1 | Parity error, sticky |
| ovr_flag | output | 1 | Overrun, sticky |
| rxi_irq | output | 1 | Receive interrupt |
| eri_irq | output | 1 | Error interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The bench sends a bad-parity character and then its retransmission. A receiver that raised data-ready on the bad copy, dropped its byte, or drove the error pulse at the wrong time or for the wrong length would differ from the model within one clock. It sends a low pulse too short to be a start bit and a glitch placed exactly on a data sample point: a receiver with no start re-check would frame garbage, and one that took a single sample would flip the bit. It also lands a parity-error clear on the same edge as a new parity error, and sends a second good byte before the first is taken. Either case catches a clear that wins over a set, or an overrun that overwrites the stored byte.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  localparam int ETU_W = 16;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_ERRWAIT,
    RX_ERRDRV,
    RX_GUARD
  } rx_state_e;

  // two of three samples decide the bit
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  // effective clocks per ETU: zero picks the default, tiny values are raised
  function automatic logic [ETU_W-1:0] eff_etu(input logic [ETU_W-1:0] etu,
                                               input logic [ETU_W-1:0] dflt);
    if (etu == '0) return dflt;
    else if (etu < ETU_W'(4)) return ETU_W'(4);
    else return etu;
  endfunction

endpackage

// File: rtl/sc_rx_sampler.sv
module sc_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic maj
);
  logic [SYNC_STAGES-1:0] sq;
  logic [2:0]             hist;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sq <= '1;
        else        sq <= line_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sq <= '1;
        else        sq <= {sq[SYNC_STAGES-2:0], line_in};
    end
  endgenerate

  assign line_s = sq[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hist <= 3'b111;
    else        hist <= {hist[1:0], line_s};

  assign maj = sc_rx_pkg::maj3(hist);
endmodule

// File: rtl/sc_rx_etu_timer.sv
module sc_rx_etu_timer #(
  parameter int ETU_W = sc_rx_pkg::ETU_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ETU_W-1:0] etu,
  output logic             half_hit,
  output logic             full_hit
);
  logic [ETU_W-1:0] cnt;
  logic [ETU_W-1:0] half_m1;
  logic [ETU_W-1:0] full_m1;

  assign half_m1  = (etu >> 1) - ETU_W'(1);
  assign full_m1  = etu - ETU_W'(1);
  assign half_hit = (cnt == half_m1);
  assign full_hit = (cnt == full_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + ETU_W'(1);
endmodule

// File: rtl/sc_rx_frame_fsm.sv
module sc_rx_frame_fsm
  import sc_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              line_s,
  input  logic              maj,
  input  logic              half_hit,
  input  logic              full_hit,
  output logic              tmr_clr,
  output logic              ev_good,
  output logic              ev_bad,
  output logic [DATA_W-1:0] frame_byte,
  output logic              drive_low
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic              par_bad;
  logic              par_done;

  assign par_bad    = ^{shreg, maj};
  assign par_done   = (state == RX_PAR) && full_hit;
  assign ev_good    = par_done && !par_bad;
  assign ev_bad     = par_done && par_bad;
  assign frame_byte = shreg;
  assign drive_low  = (state == RX_ERRDRV);

  always_comb begin
    tmr_clr = 1'b0;
    case (state)
      RX_IDLE:                 tmr_clr = 1'b1;
      RX_START, RX_ERRWAIT:    tmr_clr = half_hit;
      RX_DATA, RX_PAR,
      RX_ERRDRV, RX_GUARD:     tmr_clr = full_hit;
      default:                 tmr_clr = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
    end else begin
      case (state)
        RX_IDLE:
          if (rx_en && !line_s) state <= RX_START;
        RX_START:
          if (half_hit) begin
            bitcnt <= '0;
            state  <= maj ? RX_IDLE : RX_DATA;
          end
        RX_DATA:
          if (full_hit) begin
            shreg <= {maj, shreg[DATA_W-1:1]};
            if (bitcnt == LAST) state <= RX_PAR;
            else                bitcnt <= bitcnt + CNT_W'(1);
          end
        RX_PAR:
          if (full_hit) state <= par_bad ? RX_ERRWAIT : RX_GUARD;
        RX_ERRWAIT:
          if (half_hit) state <= RX_ERRDRV;
        RX_ERRDRV:
          if (full_hit) state <= RX_GUARD;
        RX_GUARD:
          if (full_hit) state <= RX_IDLE;
        default:
          state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_good,
  input  logic              ev_bad,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              rie,
  input  logic              dma_en,
  input  logic              dma_ack,
  input  logic              clr_rdy,
  input  logic              clr_perr,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdy,
  output logic              perr,
  output logic              ovr,
  output logic              rxi,
  output logic              eri,
  output logic              dma_req
);
  logic ovr_hit;
  logic load;
  logic rdy_set;

  assign ovr_hit = ev_good && rdy;
  assign rdy_set = ev_good && !rdy;
  assign load    = ev_bad || rdy_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rdy     <= 1'b0;
      perr    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (load) rd_data <= frame_byte;
      rdy  <= rdy_set || (rdy && !(clr_rdy || dma_ack));
      perr <= ev_bad  || (perr && !clr_perr);
      ovr  <= ovr_hit || (ovr && !clr_ovr);
    end
  end

  assign rxi     = rdy && rie;
  assign eri     = (perr || ovr) && rie;
  assign dma_req = rdy && dma_en;
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int                        DATA_W      = 8,
  parameter int                        SYNC_STAGES = 2,
  parameter logic [sc_rx_pkg::ETU_W-1:0] ETU_DEFAULT = 16'd372
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [sc_rx_pkg::ETU_W-1:0]  etu_cycles,
  input  logic                         rx_en,
  input  logic                         rie,
  input  logic                         dma_en,
  input  logic                         line_in,
  input  logic                         dma_ack,
  input  logic                         clr_rdy,
  input  logic                         clr_perr,
  input  logic                         clr_ovr,
  output logic                         line_drive_low,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rdy_flag,
  output logic                         perr_flag,
  output logic                         ovr_flag,
  output logic                         rxi_irq,
  output logic                         eri_irq,
  output logic                         dma_req
);
  localparam int ETU_W = sc_rx_pkg::ETU_W;

  logic [ETU_W-1:0]  etu_eff;
  logic              line_s;
  logic              maj;
  logic              tmr_clr;
  logic              half_hit;
  logic              full_hit;
  logic              ev_good;
  logic              ev_bad;
  logic [DATA_W-1:0] frame_byte;

  assign etu_eff = sc_rx_pkg::eff_etu(etu_cycles, ETU_DEFAULT);

  sc_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_s(line_s), .maj(maj)
  );

  sc_rx_etu_timer #(.ETU_W(ETU_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .etu(etu_eff),
    .half_hit(half_hit), .full_hit(full_hit)
  );

  sc_rx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .line_s(line_s), .maj(maj),
    .half_hit(half_hit), .full_hit(full_hit), .tmr_clr(tmr_clr),
    .ev_good(ev_good), .ev_bad(ev_bad), .frame_byte(frame_byte),
    .drive_low(line_drive_low)
  );

  sc_rx_flags #(.DATA_W(DATA_W)) u_flg (
    .clk(clk), .rst_n(rst_n), .ev_good(ev_good), .ev_bad(ev_bad),
    .frame_byte(frame_byte), .rie(rie), .dma_en(dma_en), .dma_ack(dma_ack),
    .clr_rdy(clr_rdy), .clr_perr(clr_perr), .clr_ovr(clr_ovr),
    .rd_data(rd_data), .rdy(rdy_flag), .perr(perr_flag), .ovr(ovr_flag),
    .rxi(rxi_irq), .eri(eri_irq), .dma_req(dma_req)
  );
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk #(
  parameter int DATA_W = 8,
  parameter int ETU_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ETU_W-1:0]  etu_eff,
  input logic              ev_good,
  input logic              ev_bad,
  input logic [DATA_W-1:0] frame_byte,
  input logic [DATA_W-1:0] rd_data,
  input logic              rdy_flag,
  input logic              perr_flag,
  input logic              ovr_flag,
  input logic              dma_req,
  input logic              line_drive_low,
  input logic              clr_perr
);
  logic [ETU_W-1:0] drv_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              drv_run <= '0;
    else if (line_drive_low) drv_run <= drv_run + ETU_W'(1);
    else                     drv_run <= '0;

  assert_good_sets_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_good |=> rdy_flag);

  assert_rdy_only_from_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_flag) |-> $past(ev_good));

  assert_bad_sets_perr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> perr_flag);

  assert_bad_keeps_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> rd_data == $past(frame_byte));

  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_good && rdy_flag) |=> (ovr_flag && rd_data == $past(rd_data)));

  assert_perr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !clr_perr) |=> perr_flag);

  assert_drive_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> drv_run < etu_eff);

  assert_no_dma_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bad && !rdy_flag) |=> !dma_req);

  assert_events_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_good && ev_bad));
endmodule

bind sc_char_rx sc_char_rx_chk #(.DATA_W(DATA_W), .ETU_W(sc_rx_pkg::ETU_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .etu_eff(etu_eff), .ev_good(ev_good), .ev_bad(ev_bad),
  .frame_byte(frame_byte), .rd_data(rd_data), .rdy_flag(rdy_flag),
  .perr_flag(perr_flag), .ovr_flag(ovr_flag), .dma_req(dma_req),
  .line_drive_low(line_drive_low), .clr_perr(clr_perr)
);

// File: tb/tb_sc_char_rx.sv
module tb_sc_char_rx;
  localparam int E = 16;
  localparam int H = E / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b1, rie = 1'b1, dma_en = 1'b0;
  logic        dma_ack = 1'b0, clr_rdy = 1'b0, clr_perr = 1'b0, clr_ovr = 1'b0;
  logic        bline = 1'b1;
  logic        line_in;
  logic        line_drive_low;
  logic [7:0]  rd_data;
  logic        rdy_flag, perr_flag, ovr_flag, rxi_irq, eri_irq, dma_req;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmp_on = 1'b0;

  // reference model state
  logic       m_rdy = 1'b0, m_perr = 1'b0, m_ovr = 1'b0;
  logic [7:0] m_data = 8'h00;
  int         ev_e = -1, ev_kind = 0, dlo = -1, dhi = -1;
  logic [7:0] ev_byte = 8'h00;

  always #5 clk = ~clk;

  assign line_in = bline & ~line_drive_low;

  sc_char_rx dut (
    .clk(clk), .rst_n(rst_n), .etu_cycles(16'(E)), .rx_en(rx_en), .rie(rie),
    .dma_en(dma_en), .line_in(line_in), .dma_ack(dma_ack), .clr_rdy(clr_rdy),
    .clr_perr(clr_perr), .clr_ovr(clr_ovr), .line_drive_low(line_drive_low),
    .rd_data(rd_data), .rdy_flag(rdy_flag), .perr_flag(perr_flag),
    .ovr_flag(ovr_flag), .rxi_irq(rxi_irq), .eri_irq(eri_irq), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic even_par(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    return logic'(ones % 2);
  endfunction

  // behavioural model: advances on each clock edge from the bench's view of events
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_rdy <= 1'b0; m_perr <= 1'b0; m_ovr <= 1'b0; m_data <= 8'h00;
    end else begin
      logic g, b;
      g = (cyc + 1 == ev_e) && (ev_kind == 1);
      b = (cyc + 1 == ev_e) && (ev_kind == 2);
      if (b || (g && !m_rdy)) m_data <= ev_byte;
      m_rdy  <= (g && !m_rdy) || (m_rdy && !(clr_rdy || dma_ack));
      m_perr <= b || (m_perr && !clr_perr);
      m_ovr  <= (g && m_rdy) || (m_ovr && !clr_ovr);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R1 rd_data",         32'(rd_data),   32'(m_data));
      chk("R3 rdy_flag",        32'(rdy_flag),  32'(m_rdy));
      chk("R4 perr_flag",       32'(perr_flag), 32'(m_perr));
      chk("R6 ovr_flag",        32'(ovr_flag),  32'(m_ovr));
      chk("R7 rxi_irq",         32'(rxi_irq),   32'(m_rdy & rie));
      chk("R7 eri_irq",         32'(eri_irq),   32'((m_perr | m_ovr) & rie));
      chk("R8 dma_req",         32'(dma_req),   32'(m_rdy & dma_en));
      chk("R5 line_drive_low",  32'(line_drive_low), 32'((cyc >= dlo) && (cyc < dhi)));
    end
  end

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: clr_rdy  = 1'b1;
      1: clr_perr = 1'b1;
      2: clr_ovr  = 1'b1;
      default: dma_ack = 1'b1;
    endcase
    @(negedge clk);
    clr_rdy = 1'b0; clr_perr = 1'b0; clr_ovr = 1'b0; dma_ack = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit badp, input int gbit,
                            input bit clr_at_flag);
    int n;
    logic [9:0] bits;
    @(negedge clk);
    n = cyc;
    bits = {even_par(d) ^ badp, d, 1'b0};
    if (rx_en) begin
      ev_e    = n + 3 + H + 9 * E;
      ev_kind = badp ? 2 : 1;
      ev_byte = d;
      if (badp) begin dlo = ev_e + H; dhi = ev_e + H + E; end
    end
    for (int k = 0; k < 10 * E; k++) begin
      automatic int   bi = k / E;
      automatic logic v  = bits[bi];
      if (gbit >= 0 && bi == gbit + 1 && (k % E) == H - 2) v = ~v;
      bline = v;
      if (clr_at_flag) clr_perr = (n + k == ev_e - 1);
      @(negedge clk);
    end
    clr_perr = 1'b0;
    bline = 1'b1;
    repeat (4 * E) @(negedge clk);
  endtask

  initial begin
    #(150000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset rdy",  32'(rdy_flag),  32'd0);
    chk("R9 reset perr", 32'(perr_flag), 32'd0);
    chk("R9 reset ovr",  32'(ovr_flag),  32'd0);
    chk("R5 reset drive", 32'(line_drive_low), 32'd0);
    cmp_on = 1'b1;

    // good character, LSB first
    send_frame(8'hA5, 1'b0, -1, 1'b0);
    chk("R1 byte A5", 32'(rd_data), 32'hA5);
    chk("R3 rdy after good", 32'(rdy_flag), 32'd1);
    chk("R7 rxi with rie", 32'(rxi_irq), 32'd1);
    strobe(0);

    // parity error, then the retransmission
    send_frame(8'h3C, 1'b1, -1, 1'b0);
    chk("R4 byte kept on error", 32'(rd_data), 32'h3C);
    chk("R4 no rdy on error", 32'(rdy_flag), 32'd0);
    chk("R4 perr set", 32'(perr_flag), 32'd1);
    send_frame(8'h3C, 1'b0, -1, 1'b0);
    chk("R3 retransmit rdy", 32'(rdy_flag), 32'd1);
    chk("R9 perr still set", 32'(perr_flag), 32'd1);
    strobe(1);
    strobe(0);

    // overrun
    send_frame(8'h11, 1'b0, -1, 1'b0);
    send_frame(8'h80, 1'b0, -1, 1'b0);
    chk("R6 ovr set", 32'(ovr_flag), 32'd1);
    chk("R6 first byte kept", 32'(rd_data), 32'h11);
    rie = 1'b0;
    @(negedge clk);
    chk("R7 eri masked", 32'(eri_irq), 32'd0);
    rie = 1'b1;
    strobe(2);
    strobe(0);

    // DMA trigger and acknowledge, errored frame gives no request
    dma_en = 1'b1;
    send_frame(8'h5A, 1'b0, -1, 1'b0);
    chk("R8 dma_req", 32'(dma_req), 32'd1);
    strobe(3);
    chk("R8 ack clears rdy", 32'(rdy_flag), 32'd0);
    send_frame(8'hC3, 1'b1, -1, 1'b0);
    chk("R8 no dma on error", 32'(dma_req), 32'd0);
    strobe(1);
    dma_en = 1'b0;

    // false start
    @(negedge clk);
    bline = 1'b0;
    repeat (2) @(negedge clk);
    bline = 1'b1;
    repeat (2 * E) @(negedge clk);
    chk("R2 no rdy after short pulse", 32'(rdy_flag), 32'd0);
    chk("R2 no drive after short pulse", 32'(line_drive_low), 32'd0);
    send_frame(8'h01, 1'b0, -1, 1'b0);
    chk("R2 next frame ok", 32'(rd_data), 32'h01);
    strobe(0);

    // receiver disabled
    rx_en = 1'b0;
    send_frame(8'hFF, 1'b1, -1, 1'b0);
    chk("R10 no perr while off", 32'(perr_flag), 32'd0);
    chk("R10 data untouched", 32'(rd_data), 32'h01);
    rx_en = 1'b1;

    // glitch on sample point of bit 3 and bit 6
    send_frame(8'h00, 1'b0, 3, 1'b0);
    chk("R11 glitch ignored", 32'(rd_data), 32'h00);
    strobe(0);
    send_frame(8'hFF, 1'b0, 6, 1'b0);
    chk("R11 glitch ignored high", 32'(rd_data), 32'hFF);
    strobe(0);

    // set beats clear in the same cycle
    send_frame(8'h96, 1'b1, -1, 1'b1);
    chk("R9 set wins over clear", 32'(perr_flag), 32'd1);
    strobe(1);
    @(negedge clk);
    chk("R9 cleared by strobe", 32'(perr_flag), 32'd0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule